// File: doc/BRIEF.md
# Datapath Self-Test Controller with Pseudorandom Source

This block checks the digital back end of a data converter without the analog core. When a start command is accepted, it drives a pseudorandom word stream into the datapath in place of the converter core's samples. It runs for a fixed 512 sample clocks and then stops by itself. Each cycle of the run it folds the word that comes out of the datapath into a 16-bit signature. At the end of the run it posts that signature as a low byte and a high byte. The outputs downstream stay connected the whole time, so the stream can be watched live on the serial link.

A control bit sets where each new run starts. It either picks up the generator where the previous run left off or reloads the fixed seed. When the seed is reloaded and the datapath settings stay the same, the signature repeats exactly. When the datapath settings change, the signature changes with them.

Top module: `dp_bist`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0, both signature bytes are 0, and `pn_word` shows the low 14 bits of the seed 23'h2F1C35.
- R2: A `start` high at a clock edge while idle begins a run. `busy` is high for exactly 512 consecutive cycles, starting with the cycle after that edge.
- R3: The generator is a 23-bit register. One step shifts it left by one and places bit22 XOR bit17 in bit0. Each sample clock of a run applies 14 steps. `pn_word` is bits 13:0 of the register.
- R4: During cycle k of a run (k = 0..511), `pn_word` carries the k-th generator word. Outside a run, `pn_word` holds its last value.
- R5: When a run is accepted with `pn_resume` = 0, the generator reloads the seed, so the first word of the run is the seed word. With `pn_resume` = 1, the run continues from the state the previous run left behind.
- R6: The signature is cleared when a run is accepted. On each of the 512 cycles of the run, `dp_word` is folded in with the rule: next = (sig << 1) XOR (sig[15] ? 16'h1021 : 0) XOR dp_word.
- R7: `sig_lo` (bits 7:0) and `sig_hi` (bits 15:8) change only at the edge that ends a run. At that edge they take the signature with the final word included, and they hold it until the next run ends.
- R8: `done` rises at the edge that ends a run and stays high until the next accepted start clears it. `busy` and `done` are never high together.
- R9: A `start` pulse during a run is ignored. The run length, the word stream and the signature do not change.
- R10: With the same seeded stream, two different datapath transforms produce two different signatures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a self-test run |
| pn_resume | input | 1 | 1: continue the generator stream; 0: reload the seed at start |
| dp_word | input | 16 | Word leaving the datapath under test |
| pn_word | output | 14 | Generated word fed into the datapath instead of the core sample |
| busy | output | 1 | A run is in progress |
| done | output | 1 | A run has completed since the last accepted start |
| sig_lo | output | 8 | Signature bits 7:0 |
| sig_hi | output | 8 | Signature bits 15:8 |

## Verification
The bench closes the datapath on itself with a configurable XOR transform and checks the following failure cases:
- Off-by-one run lengths: a wrong length shows as a `busy` window that is not 512 cycles, or as a signature that is missing the last word or has one word too many.
- Resume and restart mixed up: this shows as a restart whose first word is not the seed word, or as a resume whose signature matches the seeded one.
- A start accepted in the middle of a run: this would restart the counter and stretch `busy`.
- Signature bytes that follow the running register instead of being posted only at completion: these drift while `busy` is high.

// File: rtl/bist_pkg.sv
// Package: bist_pkg
// Shared constants for the datapath self-test controller: generator
// geometry, seed, signature polynomial and run length.
// Assumes: every module of the block takes its defaults from here.
package bist_pkg;
    localparam int          LFSR_W   = 23;
    localparam int          TAP_HI   = 22;
    localparam int          TAP_LO   = 17;
    localparam int          WORD_W   = 14;
    localparam logic [22:0] PN_SEED  = 23'h2F1C35;
    localparam int          SIG_W    = 16;
    localparam logic [15:0] SIG_POLY = 16'h1021;
    localparam int          DP_W     = 16;
    localparam int          RUN_LEN  = 512;
endpackage

// File: rtl/bist_pn_gen.sv
// Module: bist_pn_gen
// Word-wide pseudorandom source. It is a Fibonacci LFSR that steps
// WORD_W times per clock, so each clock gives a new word.
// Assumes: load_seed and advance are never high together, and SEED is nonzero.
module bist_pn_gen #(
    parameter int                LFSR_W = bist_pkg::LFSR_W,
    parameter int                TAP_HI = bist_pkg::TAP_HI,
    parameter int                TAP_LO = bist_pkg::TAP_LO,
    parameter int                WORD_W = bist_pkg::WORD_W,
    parameter logic [LFSR_W-1:0] SEED   = bist_pkg::PN_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_seed,
    input  logic              advance,
    output logic [WORD_W-1:0] word
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] chain [WORD_W+1];

    assign chain[0] = state_q;

    // Unrolled single-bit steps, one generate stage per step
    for (genvar g = 0; g < WORD_W; g++) begin : g_step
        assign chain[g+1] = {chain[g][LFSR_W-2:0], chain[g][TAP_HI] ^ chain[g][TAP_LO]};
    end

    // Generator state: reset or reload to the seed, or advance one word
    always_ff @(posedge clk) begin
        if (!rst_n)         state_q <= SEED;
        else if (load_seed) state_q <= SEED;
        else if (advance)   state_q <= chain[WORD_W];
    end

    assign word = state_q[WORD_W-1:0];

    // R5
    restart_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_seed |=> state_q == SEED);

    // R3
    pn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R4
    pn_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load_seed) |=> $stable(state_q));
endmodule

// File: rtl/bist_misr.sv
// Module: bist_misr
// Multiple-input signature register. It shifts left, applies the
// polynomial feedback and XORs in one data word per fold.
// Assumes: DATA_W <= SIG_W. The next value is exported so the final word
// can be captured at the same edge that folds it in.
module bist_misr #(
    parameter int               SIG_W  = bist_pkg::SIG_W,
    parameter int               DATA_W = bist_pkg::DP_W,
    parameter logic [SIG_W-1:0] POLY   = bist_pkg::SIG_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fold,
    input  logic [DATA_W-1:0] data,
    output logic [SIG_W-1:0]  sig_next
);
    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] data_ext;

    // Zero-extend the incoming word to the signature width
    always_comb begin
        data_ext = '0;
        data_ext[DATA_W-1:0] = data;
    end

    // Next signature: shift, polynomial feedback, data injection
    always_comb begin
        sig_next = {sig_q[SIG_W-2:0], 1'b0} ^ (sig_q[SIG_W-1] ? POLY : '0) ^ data_ext;
    end

    // Signature register: cleared at run start, updated on every fold
    always_ff @(posedge clk) begin
        if (!rst_n)     sig_q <= '0;
        else if (clear) sig_q <= '0;
        else if (fold)  sig_q <= sig_next;
    end

    // R6
    misr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> sig_q == '0);

    // R6
    misr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !fold) |=> $stable(sig_q));
endmodule

// File: rtl/bist_ctrl.sv
// Module: bist_ctrl
// Run sequencer. It accepts a start while idle, counts RUN_LEN busy
// cycles, flags the last one, and keeps the done flag.
// Assumes: start may arrive at any time. Starts seen while busy are dropped.
module bist_ctrl #(
    parameter int RUN_LEN = bist_pkg::RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;

    assign accept = start && !busy_q;
    assign last   = busy_q && (cnt_q == CNT_LAST);

    // Busy flag and cycle counter for the current run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (last) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Completion flag: set at run end, cleared by the next accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)      done_q <= 1'b0;
        else if (accept) done_q <= 1'b0;
        else if (last)   done_q <= 1'b1;
    end

    assign busy = busy_q;
    assign done = done_q;

    // R9
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last) |=> busy_q);

    // R2
    run_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy_q && cnt_q == '0));

    // R8
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (!busy_q && done_q));

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && done_q));
endmodule

// File: rtl/dp_bist.sv
// Module: dp_bist
// Top of the datapath self-test. It connects the sequencer, the
// pseudorandom source and the signature register, and posts the
// signature as two bytes when a run completes.
// Assumes: the datapath mux selects pn_word while busy is high. dp_word is
// the datapath output that matches pn_word in the same cycle.
module dp_bist #(
    parameter int DP_W    = bist_pkg::DP_W,
    parameter int WORD_W  = bist_pkg::WORD_W,
    parameter int RUN_LEN = bist_pkg::RUN_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pn_resume,
    input  logic [DP_W-1:0]   dp_word,
    output logic [WORD_W-1:0] pn_word,
    output logic              busy,
    output logic              done,
    output logic [7:0]        sig_lo,
    output logic [7:0]        sig_hi
);
    localparam int SIG_W = bist_pkg::SIG_W;

    logic             accept;
    logic             last;
    logic             busy_w;
    logic [SIG_W-1:0] sig_next;
    logic [SIG_W-1:0] sig_post_q;

    bist_ctrl #(.RUN_LEN(RUN_LEN)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .last   (last),
        .busy   (busy_w),
        .done   (done)
    );

    bist_pn_gen #(.WORD_W(WORD_W)) u_pn (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_seed (accept && !pn_resume),
        .advance   (busy_w),
        .word      (pn_word)
    );

    bist_misr #(.SIG_W(SIG_W), .DATA_W(DP_W)) u_misr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .fold     (busy_w),
        .data     (dp_word),
        .sig_next (sig_next)
    );

    // Posted signature: captured with the final word at the end of a run
    always_ff @(posedge clk) begin
        if (!rst_n)    sig_post_q <= '0;
        else if (last) sig_post_q <= sig_next;
    end

    assign busy   = busy_w;
    assign sig_lo = sig_post_q[7:0];
    assign sig_hi = sig_post_q[15:8];

    // R7
    sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable({sig_hi, sig_lo}));
endmodule

// File: tb/tb_dp_bist.sv
`timescale 1ns/1ps
module tb_dp_bist;
    localparam time         CLK_P  = 20ns;
    localparam logic [22:0] SEED   = 23'h2F1C35;
    localparam int          NRUN   = 512;
    localparam int          NVEC   = 6;
    // each entry: {resume bit, datapath XOR transform}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 16'h0000}, {1'b1, 16'h0000}, {1'b1, 16'h0000},
        {1'b0, 16'h0000}, {1'b0, 16'h00FF}, {1'b1, 16'hA5C3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pn_resume = 1'b0;
    logic [15:0] cfg = 16'h0;
    logic [15:0] dp_word;
    logic [13:0] pn_word;
    logic        busy, done;
    logic [7:0]  sig_lo, sig_hi;

    int total = 0;
    int bad = 0;
    logic        finished = 1'b0;
    logic [22:0] m_pn;
    logic [15:0] m_sig;
    logic [15:0] last_sig;
    logic [15:0] seeded_sig;
    logic [15:0] sig_a, sig_b;

    always #(CLK_P/2) clk = ~clk;

    // datapath under test modelled as an XOR transform of the injected word
    assign dp_word = {2'b00, pn_word} ^ cfg;

    dp_bist dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pn_resume(pn_resume),
        .dp_word(dp_word), .pn_word(pn_word), .busy(busy), .done(done),
        .sig_lo(sig_lo), .sig_hi(sig_hi)
    );

    function automatic logic [22:0] pn_adv(input logic [22:0] s);
        logic [22:0] t = s;
        for (int i = 0; i < 14; i++) t = {t[21:0], t[22] ^ t[17]};
        return t;
    endfunction

    function automatic logic [15:0] fold(input logic [15:0] s, input logic [15:0] d);
        return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0) ^ d;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one full run; mid_start pulses start during the run
    task automatic run_once(input logic resume, input logic [15:0] c, input logic mid_start);
        int pn_err = 0;
        int busy_cnt = 0;
        int sig_moved = 0;
        @(negedge clk);
        pn_resume = resume;
        cfg = c;
        start = 1'b1;
        if (!resume) m_pn = SEED;
        m_sig = 16'h0;
        @(posedge clk);
        for (int k = 0; k < NRUN; k++) begin
            @(negedge clk);
            if (k == 0) begin
                start = 1'b0;
                check("R8 done cleared by start", {31'b0, done}, 32'd0);
                if (!resume) check("R5 first word is seed", {18'b0, pn_word}, {18'b0, SEED[13:0]});
            end
            if (mid_start && k == 200) begin start = 1'b1; pn_resume = 1'b0; end
            if (mid_start && k == 201) start = 1'b0;
            if (busy) busy_cnt++;
            if (pn_word !== m_pn[13:0]) pn_err++;
            if ({sig_hi, sig_lo} !== last_sig) sig_moved++;
            m_sig = fold(m_sig, {2'b00, m_pn[13:0]} ^ c);
            m_pn = pn_adv(m_pn);
            @(posedge clk);
        end
        @(negedge clk);
        check("R2 busy cycles", busy_cnt, NRUN);
        check("R2 busy low after run", {31'b0, busy}, 32'd0);
        check("R3 R4 word stream mismatches", pn_err, 0);
        check("R7 signature still during run", sig_moved, 0);
        check("R8 done at end", {31'b0, done}, 32'd1);
        check("R6 signature", {16'b0, sig_hi, sig_lo}, {16'b0, m_sig});
        last_sig = m_sig;
        repeat (3) @(negedge clk);
        check("R4 word holds idle", {18'b0, pn_word}, {18'b0, m_pn[13:0]});
        check("R7 signature holds idle", {16'b0, sig_hi, sig_lo}, {16'b0, last_sig});
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_pn = SEED;
        last_sig = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 sig", {16'b0, sig_hi, sig_lo}, 32'd0);
        check("R1 pn_word", {18'b0, pn_word}, {18'b0, SEED[13:0]});
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_once(VEC[v][16], VEC[v][15:0], 1'b0);
            if (v == 0) seeded_sig = last_sig;
            if (v == 1) check("R5 resume differs from seeded", {31'b0, last_sig != seeded_sig}, 32'd1);
            if (v == 3) check("R5 restart repeats signature", {16'b0, last_sig}, {16'b0, seeded_sig});
        end

        // R9 start mid-run ignored
        run_once(1'b0, 16'h0000, 1'b1);
        check("R9 mid-run start ignored", {16'b0, last_sig}, {16'b0, seeded_sig});

        // R10 configuration changes signature
        run_once(1'b0, 16'h1234, 1'b0);
        sig_a = last_sig;
        run_once(1'b0, 16'h4321, 1'b0);
        sig_b = last_sig;
        check("R10 configs differ", {31'b0, sig_a != sig_b}, 32'd1);

        // R1 reset mid-idle clears flags and signature
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 done after reset", {31'b0, done}, 32'd0);
        check("R1 sig after reset", {16'b0, sig_hi, sig_lo}, 32'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule